// File: doc/BRIEF.md
# Display Register Shadow by Bus Snooping

This block keeps a private copy of the one RAM register that a numeric display shows. It sits beside an emulated processor and its emulated RAM chips and watches the decoded instruction traffic headed for them. When the processor selects an address, the block latches that selection. When the processor later writes a main character or one of the two status characters, the block checks whether the latched selection points at the configured display register. If it does, the block stores the nibble in its own shadow storage.

The block never reads the emulated RAM. The display engine therefore gets all characters of the register at once, as a flat vector, together with a sign digit and a decimal-position digit. Logic such as leading-zero suppression can use the whole register in a single cycle, with no arbitration against the processor's own accesses. A one-cycle change flag tells the display when a shadow value has actually moved.

Top module: `disp_shadow_snoop`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every shadow character, `sign_digit`, `point_digit`, `changed` and the latched selection become zero. A write that follows reset without an intervening select uses chip 0, register 0, character 0.
- R2: An operation is one cycle with `op_valid` high. `op_kind` encodes select = 2'b00, main write = 2'b01, status-0 write = 2'b10 and status-1 write = 2'b11. A select latches `sel_addr`, where bits 7:6 are the chip, bits 5:4 the register and bits 3:0 the character.
- R3: A main write whose latched chip and register equal `TARGET_CHIP`/`TARGET_REG` stores `wr_data` in character slot `shadow_chars[4*c+3:4*c]`, where c is the latched character. The new value is visible the cycle after the write.
- R4: A status-0 write with a matching latched chip and register stores `wr_data` into `sign_digit`.
- R5: A status-1 write with a matching latched chip and register stores `wr_data` into `point_digit`.
- R6: Any write whose latched chip or register differs from the target leaves all shadow outputs unchanged.
- R7: The latched selection persists across any number of writes, with no auto-increment. A new select replaces it for all later writes.
- R8: `changed` is high for exactly the one cycle in which a new shadow value first appears, and only if some stored value differs from its previous value. Rewriting an equal value gives no pulse.
- R9: With `op_valid` low, no input changes the shadow or the latched selection.
- R10: A main write alters only the addressed character; every other character keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | One decoded RAM-side operation this cycle |
| op_kind | input | 2 | Operation kind (select, main write, status-0 write, status-1 write) |
| sel_addr | input | 8 | Select address: chip, register, character |
| wr_data | input | 4 | Nibble being written |
| shadow_chars | output | NUM_CHARS*CHAR_W | All shadow characters, character 0 in the low bits |
| sign_digit | output | CHAR_W | Shadow of status character 0 (sign) |
| point_digit | output | CHAR_W | Shadow of status character 1 (decimal position) |
| changed | output | 1 | One-cycle pulse when any shadow value changed |

## Verification
On every cycle, the assertions check four things. A select loads the latched selection. A matching main or status write lands its nibble in the addressed slot. Idle cycles and writes to foreign registers leave the shadow stable. `changed` is high exactly when some shadow value differs from the previous cycle.

Other behaviours need longer stimulus, and only the bench scenarios show them. These are the whole-vector effect of filling every character, the selection staying in force across many writes, a later select redirecting writes, and the zeroed selection after reset steering writes away from the target.

// File: rtl/shadow_snoop_pkg.sv
// Package: shared types for the display-register shadow.
// Assumes the select address is 8 bits split into chip, register and character.
package shadow_snoop_pkg;

    localparam int SEL_W  = 8;
    localparam int IDX_W  = 4;

    // Decoded operation kinds presented on op_kind.
    typedef enum logic [1:0] {
        OP_SELECT   = 2'b00,
        OP_WR_MAIN  = 2'b01,
        OP_WR_STAT0 = 2'b10,
        OP_WR_STAT1 = 2'b11
    } snoop_op_e;

    // Field layout of the select address, most significant first.
    typedef struct packed {
        logic [1:0]       chip;
        logic [1:0]       regn;
        logic [IDX_W-1:0] chr;
    } sel_addr_t;

endpackage

// File: rtl/snoop_sel_latch.sv
// Module: snoop_sel_latch
// Holds the most recent select address seen on the bus.
// Assumes at most one operation per cycle; a select never coincides with a write.
module snoop_sel_latch
    import shadow_snoop_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_kind,
    input  logic [SEL_W-1:0] sel_addr,
    output sel_addr_t        sel_q
);

    logic take_sel;

    // Purpose: recognise a valid select operation.
    always_comb begin
        take_sel = op_valid && (snoop_op_e'(op_kind) == OP_SELECT);
    end

    // Purpose: latch the selection, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (take_sel) begin
            sel_q <= sel_addr_t'(sel_addr);
        end
    end

endmodule

// File: rtl/snoop_write_decode.sv
// Module: snoop_write_decode
// Turns a write operation plus the latched selection into per-slot write enables.
// Assumes the target chip/register are fixed by parameter; character indices
// at or above NUM_CHARS never enable a slot.
module snoop_write_decode
    import shadow_snoop_pkg::*;
#(
    parameter int         NUM_CHARS   = 16,
    parameter logic [1:0] TARGET_CHIP = 2'd1,
    parameter logic [1:0] TARGET_REG  = 2'd3
) (
    input  logic                 op_valid,
    input  logic [1:0]           op_kind,
    input  sel_addr_t            sel_q,
    output logic [NUM_CHARS-1:0] main_we,
    output logic                 sign_we,
    output logic                 point_we
);

    logic reg_hit;
    logic is_main;
    logic is_s0;
    logic is_s1;

    // Purpose: classify the operation and test the latched register against the target.
    always_comb begin
        reg_hit  = (sel_q.chip == TARGET_CHIP) && (sel_q.regn == TARGET_REG);
        is_main  = op_valid && (snoop_op_e'(op_kind) == OP_WR_MAIN);
        is_s0    = op_valid && (snoop_op_e'(op_kind) == OP_WR_STAT0);
        is_s1    = op_valid && (snoop_op_e'(op_kind) == OP_WR_STAT1);
        sign_we  = is_s0 && reg_hit;
        point_we = is_s1 && reg_hit;
    end

    // One enable per shadow character slot.
    for (genvar gi = 0; gi < NUM_CHARS; gi++) begin : g_we
        // Purpose: enable slot gi when the latched character index points at it.
        always_comb begin
            main_we[gi] = is_main && reg_hit && (sel_q.chr == IDX_W'(gi));
        end
    end

endmodule

// File: rtl/snoop_shadow_store.sv
// Module: snoop_shadow_store
// Shadow storage for the display register characters and two status digits.
// Detects value changes and raises a registered one-cycle change flag.
// Assumes at most one write enable is active per cycle.
module snoop_shadow_store #(
    parameter int NUM_CHARS = 16,
    parameter int CHAR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CHARS-1:0]          main_we,
    input  logic                          sign_we,
    input  logic                          point_we,
    input  logic [CHAR_W-1:0]             wdata,
    output logic [NUM_CHARS*CHAR_W-1:0]   chars_flat,
    output logic [CHAR_W-1:0]             sign_q,
    output logic [CHAR_W-1:0]             point_q,
    output logic                          changed_q
);

    logic [NUM_CHARS-1:0] slot_diff;
    logic                 sign_diff;
    logic                 point_diff;

    for (genvar gi = 0; gi < NUM_CHARS; gi++) begin : g_slot
        logic [CHAR_W-1:0] slot_q;

        // Purpose: flag that this write would alter slot gi.
        always_comb begin
            slot_diff[gi] = main_we[gi] && (slot_q != wdata);
        end

        // Purpose: store one shadow character.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (main_we[gi]) begin
                slot_q <= wdata;
            end
        end

        assign chars_flat[gi*CHAR_W +: CHAR_W] = slot_q;
    end

    // Purpose: flag status writes that alter a stored digit.
    always_comb begin
        sign_diff  = sign_we  && (sign_q  != wdata);
        point_diff = point_we && (point_q != wdata);
    end

    // Purpose: store the two status digits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q  <= '0;
            point_q <= '0;
        end else begin
            if (sign_we) begin
                sign_q <= wdata;
            end
            if (point_we) begin
                point_q <= wdata;
            end
        end
    end

    // Purpose: register the change flag so it aligns with the new stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            changed_q <= 1'b0;
        end else begin
            changed_q <= (|slot_diff) || sign_diff || point_diff;
        end
    end

endmodule

// File: rtl/disp_shadow_snoop.sv
// Module: disp_shadow_snoop (top)
// Passive snooper that mirrors one RAM register plus its sign and
// decimal-position status characters, for a display engine.
// Assumes op_kind/sel_addr/wr_data come from an already decoded instruction
// stream, one operation per cycle, qualified by op_valid.
module disp_shadow_snoop
    import shadow_snoop_pkg::*;
#(
    parameter int         NUM_CHARS   = 16,
    parameter int         CHAR_W      = 4,
    parameter logic [1:0] TARGET_CHIP = 2'd1,
    parameter logic [1:0] TARGET_REG  = 2'd3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [1:0]                  op_kind,
    input  logic [7:0]                  sel_addr,
    input  logic [CHAR_W-1:0]           wr_data,
    output logic [NUM_CHARS*CHAR_W-1:0] shadow_chars,
    output logic [CHAR_W-1:0]           sign_digit,
    output logic [CHAR_W-1:0]           point_digit,
    output logic                        changed
);

    sel_addr_t            sel_q;
    logic [NUM_CHARS-1:0] main_we;
    logic                 sign_we;
    logic                 point_we;

    snoop_sel_latch u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .sel_addr (sel_addr),
        .sel_q    (sel_q)
    );

    snoop_write_decode #(
        .NUM_CHARS   (NUM_CHARS),
        .TARGET_CHIP (TARGET_CHIP),
        .TARGET_REG  (TARGET_REG)
    ) u_dec (
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .sel_q    (sel_q),
        .main_we  (main_we),
        .sign_we  (sign_we),
        .point_we (point_we)
    );

    snoop_shadow_store #(
        .NUM_CHARS (NUM_CHARS),
        .CHAR_W    (CHAR_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_we    (main_we),
        .sign_we    (sign_we),
        .point_we   (point_we),
        .wdata      (wr_data),
        .chars_flat (shadow_chars),
        .sign_q     (sign_digit),
        .point_q    (point_digit),
        .changed_q  (changed)
    );

endmodule

// File: rtl/disp_shadow_snoop_chk.sv
// Module: disp_shadow_snoop_chk
// Cycle-by-cycle property checker for disp_shadow_snoop, attached by bind.
// Assumes the same parameters as the instance it is bound to.
module disp_shadow_snoop_chk #(
    parameter int         NUM_CHARS   = 16,
    parameter int         CHAR_W      = 4,
    parameter logic [1:0] TARGET_CHIP = 2'd1,
    parameter logic [1:0] TARGET_REG  = 2'd3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        op_valid,
    input logic [1:0]                  op_kind,
    input logic [7:0]                  sel_addr,
    input logic [CHAR_W-1:0]           wr_data,
    input logic [7:0]                  sel_q,
    input logic [NUM_CHARS*CHAR_W-1:0] shadow_chars,
    input logic [CHAR_W-1:0]           sign_digit,
    input logic [CHAR_W-1:0]           point_digit,
    input logic                        changed
);

    localparam logic [4:0] NC = 5'(NUM_CHARS);

    logic hit;
    // Purpose: latched selection points at the target register.
    always_comb begin
        hit = (sel_q[7:6] == TARGET_CHIP) && (sel_q[5:4] == TARGET_REG);
    end

    // R2: a select loads the latched selection.
    a_r2_select_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00) |=> (sel_q == $past(sel_addr)));

    // R3: a matching main write lands in the addressed slot.
    a_r3_main_store: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && hit && ({1'b0, sel_q[3:0]} < NC))
        |=> (shadow_chars[int'($past(sel_q[3:0]))*CHAR_W +: CHAR_W] == $past(wr_data)));

    // R4: a matching status-0 write sets the sign digit.
    a_r4_sign_store: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b10 && hit) |=> (sign_digit == $past(wr_data)));

    // R5: a matching status-1 write sets the decimal-position digit.
    a_r5_point_store: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b11 && hit) |=> (point_digit == $past(wr_data)));

    // R6: writes to another register leave the shadow alone.
    a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind != 2'b00 && !hit)
        |=> ($stable(shadow_chars) && $stable(sign_digit) && $stable(point_digit)));

    // R9: idle cycles change neither shadow nor selection.
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(shadow_chars) && $stable(sign_digit)
                       && $stable(point_digit) && $stable(sel_q)));

    // R8: the change flag is high exactly when some shadow value moved.
    a_r8_flag_matches_change: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (changed == (!$stable(shadow_chars) || !$stable(sign_digit)
                                      || !$stable(point_digit))));

endmodule

bind disp_shadow_snoop disp_shadow_snoop_chk #(
    .NUM_CHARS   (NUM_CHARS),
    .CHAR_W      (CHAR_W),
    .TARGET_CHIP (TARGET_CHIP),
    .TARGET_REG  (TARGET_REG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .sel_addr     (sel_addr),
    .wr_data      (wr_data),
    .sel_q        (sel_q),
    .shadow_chars (shadow_chars),
    .sign_digit   (sign_digit),
    .point_digit  (point_digit),
    .changed      (changed)
);

// File: tb/sim_disp_shadow_snoop.sv
`timescale 1ns/1ps
// Directed bench for disp_shadow_snoop; defaults: 16 chars, target chip 1, register 3.
module sim_disp_shadow_snoop;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  sel_addr = 8'h00;
    logic [3:0]  wr_data = 4'h0;
    logic [63:0] shadow_chars;
    logic [3:0]  sign_digit;
    logic [3:0]  point_digit;
    logic        changed;

    int n_chk = 0;
    int n_fail = 0;

    // Bench-side expected state
    logic [63:0] m_chars = '0;
    logic [3:0]  m_sign = '0;
    logic [3:0]  m_point = '0;

    localparam logic [1:0] K_SEL = 2'b00, K_MAIN = 2'b01, K_S0 = 2'b10, K_S1 = 2'b11;
    localparam logic [7:0] TGT = 8'h70;   // chip 1, register 3, character 0

    always #2 clk = ~clk;

    disp_shadow_snoop u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .sel_addr(sel_addr), .wr_data(wr_data), .shadow_chars(shadow_chars),
        .sign_digit(sign_digit), .point_digit(point_digit), .changed(changed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation cycle; returns at the negedge after the capturing posedge.
    task automatic do_op(input logic [1:0] k, input logic [7:0] a, input logic [3:0] d,
                         input logic v);
        @(negedge clk);
        op_valid = v; op_kind = k; sel_addr = a; wr_data = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic chk_all(input string req);
        chk(req, shadow_chars, m_chars);
        chk(req, {60'd0, sign_digit}, {60'd0, m_sign});
        chk(req, {60'd0, point_digit}, {60'd0, m_point});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_chars = '0; m_sign = '0; m_point = '0;
        chk_all("R1 reset state");
        chk("R1 changed low in reset", {63'd0, changed}, 64'd0);
        rst_n = 1'b1;
        // Selection is zero after reset: chip 0 register 0, not the target.
        do_op(K_MAIN, 8'h00, 4'h7, 1'b1);
        chk_all("R1 zero selection misses target");
        chk("R1 no change pulse", {63'd0, changed}, 64'd0);
    endtask

    task automatic t_main_write();
        do_op(K_SEL, TGT | 8'h05, 4'h0, 1'b1);
        do_op(K_MAIN, 8'h00, 4'h9, 1'b1);
        m_chars[5*4 +: 4] = 4'h9;
        chk_all("R3 R10 main write to slot 5");
        chk("R8 pulse on change", {63'd0, changed}, 64'd1);
        @(negedge clk);
        chk("R8 pulse lasts one cycle", {63'd0, changed}, 64'd0);
    endtask

    task automatic t_rewrite();
        do_op(K_MAIN, 8'h00, 4'h9, 1'b1);
        chk_all("R8 equal rewrite keeps value");
        chk("R8 no pulse on equal rewrite", {63'd0, changed}, 64'd0);
        do_op(K_MAIN, 8'h00, 4'hA, 1'b1);
        m_chars[5*4 +: 4] = 4'hA;
        chk_all("R7 selection persists across writes");
        chk("R8 pulse on second change", {63'd0, changed}, 64'd1);
    endtask

    task automatic t_status();
        do_op(K_S0, 8'h00, 4'hF, 1'b1);
        m_sign = 4'hF;
        chk_all("R4 status-0 to sign");
        chk("R8 pulse on sign", {63'd0, changed}, 64'd1);
        do_op(K_S1, 8'h00, 4'h3, 1'b1);
        m_point = 4'h3;
        chk_all("R5 status-1 to point");
    endtask

    task automatic t_foreign();
        do_op(K_SEL, 8'h35, 4'h0, 1'b1);   // chip 0, register 3
        do_op(K_MAIN, 8'h00, 4'h1, 1'b1);
        do_op(K_S0, 8'h00, 4'h2, 1'b1);
        chk_all("R6 wrong chip ignored");
        do_op(K_SEL, 8'h65, 4'h0, 1'b1);   // chip 1, register 2
        do_op(K_MAIN, 8'h00, 4'h1, 1'b1);
        do_op(K_S1, 8'h00, 4'h2, 1'b1);
        chk_all("R6 wrong register ignored");
        chk("R6 no pulse", {63'd0, changed}, 64'd0);
    endtask

    task automatic t_idle();
        do_op(K_SEL, TGT | 8'h02, 4'h0, 1'b1);
        do_op(K_MAIN, 8'h00, 4'h6, 1'b0);           // not valid
        chk_all("R9 invalid write ignored");
        do_op(K_SEL, 8'h00, 4'h0, 1'b0);            // invalid select must not move selection
        do_op(K_MAIN, 8'h00, 4'h4, 1'b1);
        m_chars[2*4 +: 4] = 4'h4;
        chk_all("R9 invalid select ignored");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) begin
            do_op(K_SEL, TGT | 8'(i), 4'h0, 1'b1);
            do_op(K_MAIN, 8'h00, 4'(i ^ 5), 1'b1);
            m_chars[i*4 +: 4] = 4'(i ^ 5);
        end
        chk_all("R3 R7 R10 full register fill");
    endtask

    initial begin
        #(4 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_main_write();
        t_rewrite();
        t_status();
        t_foreign();
        t_idle();
        t_fill();
        t_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule